// File: doc/BRIEF.md
# Packet-Parsing Integer ALU

This block is the integer execute stage of a packet-processing core. It takes an operation code, two 32-bit register values (`rs_i`, `rt_i`), a 5-bit shift amount, two 5-bit mask fields and a 16-bit immediate. It produces a 32-bit result for the destination register, the destination index and a write enable. Besides the usual add, subtract, logic, compare-and-set and shift operations, it provides field-extraction operations for parsing headers: rotate-then-mask, shift-then-mask, a split dual 16-bit add, and an AND-with-immediate that keeps the upper half of the source intact.

The result path has one register stage. An operation presented while `valid_i` is high appears on `result_o`, `wr_en_o` and `wr_idx_o` one clock later. All arithmetic wraps around and has no overflow signal. Register 0 is never written, and its result reads as zero.

Top module: `pktalu_core`

## Requirements
- R1: Outputs are registered. An operation presented at a rising edge shows on the outputs from that edge until the next one. While reset is active, `result_o`, `wr_en_o` and `wr_idx_o` are 0. Opcodes: ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, SLT=6, SLTU=7, ADDI=8, SLTI=9, SLTIU=10, ANDI=11, ORI=12, XORI=13, LUI=14, SLL=15, SRL=16, SRA=17, SLLV=18, SRLV=19, SRAV=20, DADD16=21, ROTMSK=22, SHLMSK=23, SHRMSK=24, ANDHI=25.
- R2: ADD and SUB give rs+rt and rs−rt modulo 2^32. ADDI adds rs to the sign-extended immediate, also modulo 2^32.
- R3: AND, OR, XOR and NOR combine rs with rt. ANDI, ORI and XORI combine rs with the zero-extended immediate. LUI gives the immediate shifted left by 16.
- R4: SLT and SLTU compare rs with rt as signed and as unsigned numbers. SLTI and SLTIU compare rs with the sign-extended immediate, SLTIU as an unsigned compare. The result is 1 when rs is the smaller, otherwise 0.
- R5: SLL, SRL and SRA shift rt by the shift amount. SLLV, SRLV and SRAV shift rt by bits 4:0 of rs. SRA and SRAV fill with copies of rt bit 31.
- R6: DADD16 adds the low halves and the high halves of rs and rt independently, drops each carry, and packs the results as {high sum, low sum}.
- R7: ROTMSK rotates rt right by the shift amount. It then ANDs the result with all-ones shifted right by `maskl_i` and with all-ones shifted left by `maskr_i`.
- R8: SHLMSK gives (rt << shamt) & (all-ones >> rs). SHRMSK gives (rt >> shamt) & (all-ones << rs). The mask count is the whole rs value, so 32 or more gives a zero mask.
- R9: ANDHI ANDs rs with the sign-extended immediate ORed with 0xFFFF0000. Bits 31:16 of rs always pass through to the result.
- R10: When the destination index is 0, `wr_en_o` stays low and `result_o` is 0.
- R11: When `valid_i` is low, `wr_en_o` stays low. An opcode above 25 gives a result of 0 and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| shamt_i | input | 5 | Fixed shift / rotate amount |
| maskl_i | input | 5 | Left mask count for rotate-and-mask |
| maskr_i | input | 5 | Right mask count for rotate-and-mask |
| imm_i | input | 16 | Immediate |
| dest_i | input | 5 | Destination register index |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered write enable |
| wr_idx_o | output | 5 | Registered destination index |

## Verification
On every cycle, the assertions check the protections: no write is enabled to index 0, the index-0 result is 0, an idle cycle produces no write, compare results are a single bit, ANDHI passes the upper half of rs through, and a register-register add shows up one cycle later. The arithmetic content of every other operation can only be shown by the bench's sweeps. These sweeps cover all opcodes over corner and pseudo-random operands, every shift amount from 0 to 31, and all 1024 pairs of left and right mask counts for rotate-and-mask, with each expected value worked out bit by bit.

// File: rtl/pktalu_pkg.sv
package pktalu_pkg;

    localparam int XLEN   = 32;
    localparam int HALF   = 16;
    localparam int SHW    = 5;
    localparam int IMMW   = 16;
    localparam int REGW   = 5;
    localparam int OPW    = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_AND    = 5'd2,
        OP_OR     = 5'd3,
        OP_XOR    = 5'd4,
        OP_NOR    = 5'd5,
        OP_SLT    = 5'd6,
        OP_SLTU   = 5'd7,
        OP_ADDI   = 5'd8,
        OP_SLTI   = 5'd9,
        OP_SLTIU  = 5'd10,
        OP_ANDI   = 5'd11,
        OP_ORI    = 5'd12,
        OP_XORI   = 5'd13,
        OP_LUI    = 5'd14,
        OP_SLL    = 5'd15,
        OP_SRL    = 5'd16,
        OP_SRA    = 5'd17,
        OP_SLLV   = 5'd18,
        OP_SRLV   = 5'd19,
        OP_SRAV   = 5'd20,
        OP_DADD16 = 5'd21,
        OP_ROTMSK = 5'd22,
        OP_SHLMSK = 5'd23,
        OP_SHRMSK = 5'd24,
        OP_ANDHI  = 5'd25
    } alu_op_e;

    localparam logic [OPW-1:0] OP_LAST = 5'd25;

    function automatic logic op_is_legal(input logic [OPW-1:0] code);
        return code <= OP_LAST;
    endfunction

endpackage

// File: rtl/pktalu_imm_ext.sv
module pktalu_imm_ext #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  sext_o,
    output logic [W-1:0]  zext_o,
    output logic [W-1:0]  ones_hi_o,
    output logic [W-1:0]  upper_o
);
    localparam int PADW = W - IW;

    logic [W-1:0] hi_ones;

    always_comb begin
        sext_o    = {{PADW{imm_i[IW-1]}}, imm_i};
        zext_o    = {{PADW{1'b0}}, imm_i};
        hi_ones   = {{PADW{1'b1}}, {IW{1'b0}}};
        ones_hi_o = sext_o | hi_ones;
        upper_o   = zext_o << IW;
    end

endmodule

// File: rtl/pktalu_arith_unit.sv
module pktalu_arith_unit #(
    parameter int W    = 32,
    parameter int HW   = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output logic         lt_s_o,
    output logic         lt_u_o,
    output logic [W-1:0] lanes_o
);
    localparam int LANES = W / HW;

    always_comb begin
        sum_o  = a_i + b_i;
        diff_o = a_i - b_i;
        lt_s_o = $signed(a_i) < $signed(b_i);
        lt_u_o = a_i < b_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_o[g*HW +: HW] = a_i[g*HW +: HW] + b_i[g*HW +: HW];
    end

endmodule

// File: rtl/pktalu_bitwise_unit.sv
module pktalu_bitwise_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] nor_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
        nor_o = ~(a_i | b_i);
    end

endmodule

// File: rtl/pktalu_shift_unit.sv
module pktalu_shift_unit #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic [W-1:0]  cnt_reg_i,
    input  logic [SW-1:0] maskl_i,
    input  logic [SW-1:0] maskr_i,
    output logic [W-1:0]  shl_o,
    output logic [W-1:0]  shr_o,
    output logic [W-1:0]  sar_o,
    output logic [W-1:0]  rotmsk_o,
    output logic [W-1:0]  shlmsk_o,
    output logic [W-1:0]  shrmsk_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] rot;
    logic [W-1:0] keep_left;
    logic [W-1:0] keep_right;
    logic [W-1:0] reg_mask_lo;
    logic [W-1:0] reg_mask_hi;

    for (genvar i = 0; i < W; i++) begin : g_rot
        logic [SW-1:0] src;
        assign src    = SW'(i) + amt_i;
        assign rot[i] = val_i[src];
    end

    always_comb begin
        shl_o       = val_i << amt_i;
        shr_o       = val_i >> amt_i;
        sar_o       = W'($signed(val_i) >>> amt_i);
        keep_left   = ALL_ONES >> maskl_i;
        keep_right  = ALL_ONES << maskr_i;
        reg_mask_lo = ALL_ONES >> cnt_reg_i;
        reg_mask_hi = ALL_ONES << cnt_reg_i;
        rotmsk_o    = rot & keep_left & keep_right;
        shlmsk_o    = shl_o & reg_mask_lo;
        shrmsk_o    = shr_o & reg_mask_hi;
    end

endmodule

// File: rtl/pktalu_core.sv
module pktalu_core
    import pktalu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int HW   = HALF,
    parameter int SW   = SHW,
    parameter int IW   = IMMW,
    parameter int RW   = REGW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  rs_i,
    input  logic [W-1:0]  rt_i,
    input  logic [SW-1:0] shamt_i,
    input  logic [SW-1:0] maskl_i,
    input  logic [SW-1:0] maskr_i,
    input  logic [IW-1:0] imm_i,
    input  logic [RW-1:0] dest_i,
    output logic [W-1:0]  result_o,
    output logic          wr_en_o,
    output logic [RW-1:0] wr_idx_o
);
    localparam logic [W-1:0] ZERO = '0;

    alu_op_e      op;
    logic         legal;
    logic         dest_zero;

    logic [W-1:0] imm_sext, imm_zext, imm_ones_hi, imm_upper;
    logic [W-1:0] arith_b, logic_b;
    logic [SW-1:0] shift_amt;

    logic [W-1:0] sum, diff, lanes;
    logic         lt_s, lt_u;
    logic [W-1:0] v_and, v_or, v_xor, v_nor;
    logic [W-1:0] v_shl, v_shr, v_sar, v_rotmsk, v_shlmsk, v_shrmsk;

    logic [W-1:0] result_next;
    logic         wr_next;

    assign op        = alu_op_e'(op_i);
    assign legal     = op_is_legal(op_i);
    assign dest_zero = (dest_i == '0);

    pktalu_imm_ext #(.W(W), .IW(IW)) u_imm (
        .imm_i     (imm_i),
        .sext_o    (imm_sext),
        .zext_o    (imm_zext),
        .ones_hi_o (imm_ones_hi),
        .upper_o   (imm_upper)
    );

    // operand routing per operation class
    always_comb begin
        unique case (op)
            OP_ADDI, OP_SLTI, OP_SLTIU: arith_b = imm_sext;
            default:                    arith_b = rt_i;
        endcase
        unique case (op)
            OP_ANDI, OP_ORI, OP_XORI: logic_b = imm_zext;
            OP_ANDHI:                 logic_b = imm_ones_hi;
            default:                  logic_b = rt_i;
        endcase
        unique case (op)
            OP_SLLV, OP_SRLV, OP_SRAV: shift_amt = rs_i[SW-1:0];
            default:                   shift_amt = shamt_i;
        endcase
    end

    pktalu_arith_unit #(.W(W), .HW(HW)) u_arith (
        .a_i     (rs_i),
        .b_i     (arith_b),
        .sum_o   (sum),
        .diff_o  (diff),
        .lt_s_o  (lt_s),
        .lt_u_o  (lt_u),
        .lanes_o (lanes)
    );

    pktalu_bitwise_unit #(.W(W)) u_bitwise (
        .a_i   (rs_i),
        .b_i   (logic_b),
        .and_o (v_and),
        .or_o  (v_or),
        .xor_o (v_xor),
        .nor_o (v_nor)
    );

    pktalu_shift_unit #(.W(W), .SW(SW)) u_shift (
        .val_i     (rt_i),
        .amt_i     (shift_amt),
        .cnt_reg_i (rs_i),
        .maskl_i   (maskl_i),
        .maskr_i   (maskr_i),
        .shl_o     (v_shl),
        .shr_o     (v_shr),
        .sar_o     (v_sar),
        .rotmsk_o  (v_rotmsk),
        .shlmsk_o  (v_shlmsk),
        .shrmsk_o  (v_shrmsk)
    );

    // result select
    always_comb begin
        result_next = ZERO;
        if (legal && !dest_zero) begin
            unique case (op)
                OP_ADD, OP_ADDI:               result_next = sum;
                OP_SUB:                        result_next = diff;
                OP_AND, OP_ANDI, OP_ANDHI:     result_next = v_and;
                OP_OR, OP_ORI:                 result_next = v_or;
                OP_XOR, OP_XORI:               result_next = v_xor;
                OP_NOR:                        result_next = v_nor;
                OP_SLT, OP_SLTI:               result_next = {{(W-1){1'b0}}, lt_s};
                OP_SLTU, OP_SLTIU:             result_next = {{(W-1){1'b0}}, lt_u};
                OP_LUI:                        result_next = imm_upper;
                OP_SLL, OP_SLLV:               result_next = v_shl;
                OP_SRL, OP_SRLV:               result_next = v_shr;
                OP_SRA, OP_SRAV:               result_next = v_sar;
                OP_DADD16:                     result_next = lanes;
                OP_ROTMSK:                     result_next = v_rotmsk;
                OP_SHLMSK:                     result_next = v_shlmsk;
                OP_SHRMSK:                     result_next = v_shrmsk;
                default:                       result_next = ZERO;
            endcase
        end
        wr_next = valid_i && legal && !dest_zero;
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= ZERO;
            wr_en_o  <= 1'b0;
            wr_idx_o <= '0;
        end else begin
            result_o <= result_next;
            wr_en_o  <= wr_next;
            wr_idx_o <= dest_i;
        end
    end

endmodule

// File: rtl/pktalu_core_chk.sv
module pktalu_core_chk
    import pktalu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [4:0]  op_i,
    input logic [31:0] rs_i,
    input logic [31:0] rt_i,
    input logic [4:0]  dest_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic [4:0]  wr_idx_o
);
    p_no_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o != 5'd0));

    p_zero_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dest_i) == 5'd0) |-> (result_o == 32'd0));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> !wr_en_o);

    p_compare_is_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU ||
                          $past(op_i) == OP_SLTI || $past(op_i) == OP_SLTIU))
        |-> (result_o[31:1] == 31'd0));

    p_upper_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_ANDHI && $past(dest_i) != 5'd0)
        |-> (result_o[31:16] == $past(rs_i[31:16])));

    p_add_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_ADD && $past(dest_i) != 5'd0)
        |-> (result_o == $past(rs_i + rt_i)));

endmodule

bind pktalu_core pktalu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .rs_i     (rs_i),
    .rt_i     (rt_i),
    .dest_i   (dest_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .wr_idx_o (wr_idx_o)
);

// File: tb/pktalu_core_test.sv
module pktalu_core_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] rs_i = '0, rt_i = '0;
    logic [4:0]  shamt_i = '0, maskl_i = '0, maskr_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  dest_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    pktalu_core uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .rs_i(rs_i), .rt_i(rt_i), .shamt_i(shamt_i), .maskl_i(maskl_i),
        .maskr_i(maskr_i), .imm_i(imm_i), .dest_i(dest_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 8:             return "R2";
            2, 3, 4, 5, 11, 12, 13, 14: return "R3";
            6, 7, 9, 10:         return "R4";
            15, 16, 17, 18, 19, 20: return "R5";
            21:                  return "R6";
            22:                  return "R7";
            23, 24:              return "R8";
            25:                  return "R9";
            default:             return "R11";
        endcase
    endfunction

    function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                          input logic [31:0] b, input int sh,
                                          input int ml, input int mr,
                                          input logic [15:0] im);
        logic [31:0] sx, zx, r, lo_keep, hi_keep;
        longint sa, sb;
        int cnt;
        sx = {{16{im[15]}}, im};
        zx = {16'd0, im};
        sa = longint'($signed(a));
        r  = '0;
        case (op)
            0:  r = a + b;
            1:  r = a - b;
            2:  r = a & b;
            3:  r = a | b;
            4:  r = a ^ b;
            5:  r = ~(a | b);
            6:  begin sb = longint'($signed(b));  r = (sa < sb) ? 32'd1 : 32'd0; end
            7:  r = ({1'b0, a} < {1'b0, b}) ? 32'd1 : 32'd0;
            8:  r = a + sx;
            9:  begin sb = longint'($signed(sx)); r = (sa < sb) ? 32'd1 : 32'd0; end
            10: r = ({1'b0, a} < {1'b0, sx}) ? 32'd1 : 32'd0;
            11: r = a & zx;
            12: r = a | zx;
            13: r = a ^ zx;
            14: r = {im, 16'd0};
            15, 18, 16, 19, 17, 20: begin
                cnt = (op >= 18) ? int'(a[4:0]) : sh;
                for (int i = 0; i < 32; i++) begin
                    if (op == 15 || op == 18)
                        r[i] = (i - cnt >= 0) ? b[i - cnt] : 1'b0;
                    else if (op == 16 || op == 19)
                        r[i] = (i + cnt <= 31) ? b[i + cnt] : 1'b0;
                    else
                        r[i] = (i + cnt <= 31) ? b[i + cnt] : b[31];
                end
            end
            21: r = {16'(a[31:16] + b[31:16]), 16'(a[15:0] + b[15:0])};
            22: for (int i = 0; i < 32; i++)
                    r[i] = b[(i + sh) % 32] && (i <= 31 - ml) && (i >= mr);
            23, 24: for (int i = 0; i < 32; i++) begin
                    if (op == 23)
                        r[i] = (i - sh >= 0) && b[(i - sh) & 31] &&
                               (a < 32) && (i <= 31 - int'(a));
                    else
                        r[i] = (i + sh <= 31) && b[(i + sh) & 31] &&
                               (a < 32) && (i >= int'(a));
                end
            25: r = {a[31:16], a[15:0] & im};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b,
                         input int sh, input int ml, input int mr,
                         input logic [15:0] im, input logic [4:0] d, input logic v);
        @(negedge clk);
        op_i = 5'(op); rs_i = a; rt_i = b; shamt_i = 5'(sh);
        maskl_i = 5'(ml); maskr_i = 5'(mr); imm_i = im; dest_i = d; valid_i = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        logic [15:0] im;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset result", result_o, 32'd0);
        check("R1", "reset wr_en", {31'd0, wr_en_o}, 32'd0);
        check("R1", "reset idx", {27'd0, wr_idx_o}, 32'd0);
        rst_n = 1'b1;

        // sweep every legal opcode over corner and pseudo-random operands
        for (int op = 0; op <= 25; op++) begin
            for (int k = 0; k < 64; k++) begin
                case (k)
                    0: begin a = 32'h0; b = 32'h0; im = 16'h0; end
                    1: begin a = '1; b = '1; im = 16'hFFFF; end
                    2: begin a = 32'h8000_0000; b = 32'h7FFF_FFFF; im = 16'h8000; end
                    3: begin a = 32'h7FFF_FFFF; b = 32'h8000_0000; im = 16'h7FFF; end
                    default: begin
                        a = next_rand(); b = next_rand(); im = next_rand()[15:0];
                        if (k % 3 == 0) a = 32'(k % 34);
                    end
                endcase
                issue(op, a, b, k % 32, (k * 7) % 32, (k * 11) % 32, im,
                      5'((k % 31) + 1), 1'b1);
                check(tag_of(op), $sformatf("op %0d k %0d", op, k), result_o,
                      model(op, a, b, k % 32, (k * 7) % 32, (k * 11) % 32, im));
                check("R1", "write enable on live op", {31'd0, wr_en_o}, 32'd1);
                check("R1", "dest index", {27'd0, wr_idx_o}, 32'((k % 31) + 1));
            end
        end

        // R7: all left/right mask pairs
        for (int ml = 0; ml < 32; ml++) begin
            for (int mr = 0; mr < 32; mr++) begin
                b = 32'hA5C3_3C5A ^ 32'(ml * 97 + mr);
                issue(22, 32'h0, b, (ml + mr) % 32, ml, mr, 16'h0, 5'd7, 1'b1);
                check("R7", $sformatf("rotmsk ml %0d mr %0d", ml, mr), result_o,
                      model(22, 32'h0, b, (ml + mr) % 32, ml, mr, 16'h0));
            end
        end

        // R8: mask count at 31, 32 and large
        issue(23, 32'd31, 32'hFFFF_FFFF, 0, 0, 0, 16'h0, 5'd3, 1'b1);
        check("R8", "shlmsk rs=31", result_o, 32'h0000_0001);
        issue(23, 32'd32, 32'hFFFF_FFFF, 0, 0, 0, 16'h0, 5'd3, 1'b1);
        check("R8", "shlmsk rs=32", result_o, 32'h0);
        issue(24, 32'h0001_0000, 32'hFFFF_FFFF, 4, 0, 0, 16'h0, 5'd3, 1'b1);
        check("R8", "shrmsk rs large", result_o, 32'h0);

        // R10: destination 0
        issue(0, 32'd5, 32'd6, 0, 0, 0, 16'h0, 5'd0, 1'b1);
        check("R10", "dest0 result", result_o, 32'd0);
        check("R10", "dest0 wr_en", {31'd0, wr_en_o}, 32'd0);

        // R11: idle cycle and undefined opcodes
        issue(0, 32'd5, 32'd6, 0, 0, 0, 16'h0, 5'd4, 1'b0);
        check("R11", "idle wr_en", {31'd0, wr_en_o}, 32'd0);
        for (int op = 26; op < 32; op++) begin
            issue(op, 32'hDEAD_BEEF, 32'h1234_5678, 3, 1, 1, 16'hFFFF, 5'd9, 1'b1);
            check("R11", $sformatf("undefined op %0d result", op), result_o, 32'd0);
            check("R11", $sformatf("undefined op %0d wr_en", op), {31'd0, wr_en_o}, 32'd0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule